// File: doc/BRIEF.md
# CAN Controller Host Register and Interrupt Unit

This unit is the host-facing register file of a CAN controller. A host reaches it over a byte-wide synchronous bus with a 5-bit address. Through that bus the host sets the mode, issues commands, reads status, and reads and clears interrupt flags. The unit collects transmit and receive events into status and flag bits, and it drives one level-sensitive interrupt line that is gated by an enable register.

The controller is either in reset mode or in operating mode. The address window at 16..28 means something different in each mode. In reset mode it holds the acceptance code and mask bytes. In operating mode it takes the bytes of the outgoing frame.

A transmit command hands the frame buffer to an external frame port as a single-cycle pulse, and the transmission counts as complete at once. The receive path outside this block reports each stored message and each overrun on dedicated pulse inputs.

Top module: `canHostRegs`

## Requirements
- R1: After reset the mode register reads 0x01 (reset mode), status reads 0x3C, and the interrupt flags, the interrupt enable and the clock-divider register (address 31) read 0x00. The irq output is low.
- R2: A write to the mode register (address 0) stores only bits 4:0, so bits 7:5 read back as 0. A write that takes bit 0 from 1 to 0 enters operating mode and zeroes the pending-message count. A later read of the interrupt register therefore does not re-assert the receive flag.
- R3: irq is high exactly when the interrupt-enable register (address 4) and the flag register (address 3) share a set bit.
- R4: A read of address 3 returns the flags and clears them. If messages are still pending after that cycle, flag bit 0 (receive) is set again at once.
- R5: In operating mode, a write to address 1 with bit 0 set raises txValid for exactly one cycle, starting the cycle after the write. txData carries the transmit buffer. The same command sets status bits 3:2, clears status bit 5 and sets flag bit 1 (transmit). In reset mode the same command is ignored.
- R6: In operating mode, a write to address 16+i (i = 0..12) stores byte i of the transmit buffer, which appears on txData[8i+7:8i]. Only a write to address 16 sets status bit 5. Reads of 16..28 return 0x00.
- R7: In reset mode, addresses 16..23 are eight acceptance bytes (four code, then four mask) that can be read back. Reads of 24..28 return 0x00.
- R8: Address 1 reads 0x00, addresses 5..15 read 0x00, addresses 29 and 30 read 0xFF, and address 31 is a read/write clock-divider byte.
- R9: Writes to the status register (address 2) and the flag register (address 3) have no effect.
- R10: A rxMsgIn pulse in operating mode increments the pending count and sets status bit 0 and flag bit 0. In reset mode the pulse is ignored. A write to address 1 with bit 2 set releases one message. When the count reaches zero it clears status bit 0 and flag bit 0. A release with nothing pending has no effect.
- R11: A rxOverrun pulse sets status bit 1 and flag bit 3. A write to address 1 with bit 3 set clears both.
- R12: When an event and a clear fall in the same cycle, the event wins. An overrun during a flag read or during a clear-overrun command stays flagged. A message arrival during a release leaves the count unchanged.
- R13: Read data appears on rdata in the cycle after re and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe; read side effects occur in this cycle |
| rdata | output | 8 | Registered read data |
| rxMsgIn | input | 1 | Pulse: one received message was stored |
| rxOverrun | input | 1 | Pulse: a received message was lost to overrun |
| irq | output | 1 | Level interrupt request |
| txValid | output | 1 | One-cycle frame handoff strobe |
| txData | output | 104 | Transmit buffer, byte i at bits 8i+7:8i |

## Verification
The hazard is a clearing action and a setting event landing on the same clock edge. That happens when a flag read or a clear-overrun command coincides with an overrun pulse, or when a release command coincides with a message arrival. The bench drives the bus strobe and the event input on the same falling edge. It then judges the result through later reads: the overrun flag and status bit must survive, and the receive status must show one message still pending.

// File: rtl/canRegPkg.sv
package canRegPkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_MODE = 5'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 5'd3;
  localparam logic [ADDR_W-1:0] A_IE   = 5'd4;
  localparam logic [ADDR_W-1:0] A_RSV_LO = 5'd5;
  localparam logic [ADDR_W-1:0] A_RSV_HI = 5'd15;
  localparam logic [ADDR_W-1:0] A_WIN  = 5'd16;
  localparam logic [ADDR_W-1:0] A_CLK  = 5'd31;

  // control-to-datapath strobes
  typedef struct packed {
    logic modeWr;
    logic txReq;
    logic relReq;
    logic ovrClr;
    logic ieWr;
    logic clkWr;
    logic winWr;
    logic flagRead;
  } ctrlStrb_t;
endpackage

// File: rtl/canRegCtrl.sv
module canRegCtrl
  import canRegPkg::*;
#(
  parameter int TX_BYTES = 13
) (
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmdTxBit,
  input  logic              cmdRelBit,
  input  logic              cmdOvrBit,
  input  logic              inReset,
  output ctrlStrb_t         strb
);
  localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(int'(A_WIN) + TX_BYTES - 1);

  logic inWin;
  logic cmdWr;

  assign inWin = (addr >= A_WIN) && (addr <= WIN_LAST);
  assign cmdWr = we && (addr == A_CMD);

  always_comb begin
    strb          = '0;
    strb.modeWr   = we && (addr == A_MODE);
    strb.txReq    = cmdWr && cmdTxBit && !inReset;
    strb.relReq   = cmdWr && cmdRelBit;
    strb.ovrClr   = cmdWr && cmdOvrBit;
    strb.ieWr     = we && (addr == A_IE);
    strb.clkWr    = we && (addr == A_CLK);
    strb.winWr    = we && inWin;
    strb.flagRead = re && (addr == A_FLAG);
  end
endmodule

// File: rtl/canRegDp.sv
module canRegDp
  import canRegPkg::*;
#(
  parameter int TX_BYTES  = 13,
  parameter int ACC_BYTES = 8,
  parameter int CNT_W     = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrb_t               strb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    re,
  input  logic                    rxMsgIn,
  input  logic                    rxOverrun,
  output logic                    inReset,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irq,
  output logic                    txValid,
  output logic [TX_BYTES*DATA_W-1:0] txData
);
  localparam int TX_IW  = $clog2(TX_BYTES);
  localparam int ACC_IW = $clog2(ACC_BYTES);
  localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(int'(A_WIN) + TX_BYTES - 1);
  localparam logic [ADDR_W-1:0] ACC_N    = ADDR_W'(ACC_BYTES);
  localparam logic [7:0] STAT_RST = 8'h3C;

  logic [4:0]        modeQ;
  logic [7:0]        statQ, statNext;
  logic [7:0]        flagQ, flagNext;
  logic [7:0]        ieQ, clkQ;
  logic [CNT_W-1:0]  msgCnt, msgNext;
  logic [DATA_W-1:0] accQ [ACC_BYTES];
  logic [DATA_W-1:0] txBufQ [TX_BYTES];
  logic              txValidQ;
  logic [DATA_W-1:0] rdataQ, rdVal;

  logic [ADDR_W-1:0] winOff;
  logic [TX_IW-1:0]  txIdx;
  logic [ACC_IW-1:0] accIdx;
  logic              inWin, rxAccept, relDo, leaveReset;

  assign inReset    = modeQ[0];
  assign winOff     = addr - A_WIN;
  assign txIdx      = TX_IW'(winOff);
  assign accIdx     = ACC_IW'(winOff);
  assign inWin      = (addr >= A_WIN) && (addr <= WIN_LAST);
  assign rxAccept   = rxMsgIn && !inReset;
  assign relDo      = strb.relReq && (msgCnt != '0);
  assign leaveReset = strb.modeWr && modeQ[0] && !wdata[0];

  // pending-message counter: arrival and release cancel out
  always_comb begin
    msgNext = msgCnt;
    if (leaveReset)                                 msgNext = '0;
    else if (rxAccept && !relDo && !(&msgCnt))      msgNext = msgCnt + 1'b1;
    else if (relDo && !rxAccept)                    msgNext = msgCnt - 1'b1;
  end

  // flags: clears first, then events, so events win
  always_comb begin
    flagNext = strb.flagRead ? {7'b0, (msgNext != '0)} : flagQ;
    if (relDo && (msgNext == '0)) flagNext[0] = 1'b0;
    if (strb.ovrClr)              flagNext[3] = 1'b0;
    if (strb.txReq)               flagNext[1] = 1'b1;
    if (rxAccept)                 flagNext[0] = 1'b1;
    if (rxOverrun)                flagNext[3] = 1'b1;
  end

  always_comb begin
    statNext = statQ;
    if (strb.txReq) begin
      statNext[3:2] = 2'b11;
      statNext[5]   = 1'b0;
    end
    if (strb.winWr && !inReset && (winOff == '0)) statNext[5] = 1'b1;
    if (relDo && (msgNext == '0)) statNext[0] = 1'b0;
    if (rxAccept)                 statNext[0] = 1'b1;
    if (strb.ovrClr)              statNext[1] = 1'b0;
    if (rxOverrun)                statNext[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 5'h01;
      statQ    <= STAT_RST;
      flagQ    <= '0;
      ieQ      <= '0;
      clkQ     <= '0;
      msgCnt   <= '0;
      txValidQ <= 1'b0;
    end else begin
      if (strb.modeWr) modeQ <= wdata[4:0];
      if (strb.ieWr)   ieQ   <= wdata;
      if (strb.clkWr)  clkQ  <= wdata;
      statQ    <= statNext;
      flagQ    <= flagNext;
      msgCnt   <= msgNext;
      txValidQ <= strb.txReq;
    end
  end

  for (genvar i = 0; i < TX_BYTES; i++) begin : gTxBuf
    always_ff @(posedge clk) begin
      if (!rstN)
        txBufQ[i] <= '0;
      else if (strb.winWr && !inReset && (txIdx == TX_IW'(i)))
        txBufQ[i] <= wdata;
    end
    assign txData[i*DATA_W +: DATA_W] = txBufQ[i];
  end

  for (genvar j = 0; j < ACC_BYTES; j++) begin : gAcc
    always_ff @(posedge clk) begin
      if (!rstN)
        accQ[j] <= '0;
      else if (strb.winWr && inReset && (winOff < ACC_N) && (accIdx == ACC_IW'(j)))
        accQ[j] <= wdata;
    end
  end

  always_comb begin
    rdVal = 8'hFF;
    unique case (addr)
      A_MODE: rdVal = {3'b0, modeQ};
      A_CMD:  rdVal = 8'h00;
      A_STAT: rdVal = statQ;
      A_FLAG: rdVal = flagQ;
      A_IE:   rdVal = ieQ;
      A_CLK:  rdVal = clkQ;
      default: begin
        if (inWin)
          rdVal = (inReset && (winOff < ACC_N)) ? accQ[accIdx] : 8'h00;
        else if ((addr >= A_RSV_LO) && (addr <= A_RSV_HI))
          rdVal = 8'h00;
        else
          rdVal = 8'hFF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)   rdataQ <= '0;
    else if (re) rdataQ <= rdVal;
  end

  assign rdata   = rdataQ;
  assign txValid = txValidQ;
  assign irq     = |(ieQ & flagQ);

  // R5
  tx_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txReq |=> (flagQ[1] && (statQ[3:2] == 2'b11) && !statQ[5] && txValidQ));

  // R4
  rx_reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagRead && (msgCnt != '0) && !strb.relReq && !strb.modeWr) |=> flagQ[0]);

  // R2
  mode_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> (modeQ == $past(wdata[4:0])));

  // R2
  leave_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeQ[0]) |-> (msgCnt == '0));

  // R11
  ovr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> (statQ[1] && flagQ[3]));
endmodule

// File: rtl/canHostRegs.sv
module canHostRegs
  import canRegPkg::*;
#(
  parameter int TX_BYTES  = 13,
  parameter int ACC_BYTES = 8,
  parameter int CNT_W     = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [4:0]                 addr,
  input  logic [7:0]                 wdata,
  input  logic                       we,
  input  logic                       re,
  output logic [7:0]                 rdata,
  input  logic                       rxMsgIn,
  input  logic                       rxOverrun,
  output logic                       irq,
  output logic                       txValid,
  output logic [TX_BYTES*8-1:0]      txData
);
  ctrlStrb_t strb;
  logic      inReset;

  canRegCtrl #(.TX_BYTES(TX_BYTES)) u_ctrl (
    .we        (we),
    .re        (re),
    .addr      (addr),
    .cmdTxBit  (wdata[0]),
    .cmdRelBit (wdata[2]),
    .cmdOvrBit (wdata[3]),
    .inReset   (inReset),
    .strb      (strb)
  );

  canRegDp #(.TX_BYTES(TX_BYTES), .ACC_BYTES(ACC_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .wdata     (wdata),
    .re        (re),
    .rxMsgIn   (rxMsgIn),
    .rxOverrun (rxOverrun),
    .inReset   (inReset),
    .rdata     (rdata),
    .irq       (irq),
    .txValid   (txValid),
    .txData    (txData)
  );
endmodule

// File: tb/canHostRegs_tb.sv
module canHostRegs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TXB = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0, re = 1'b0, rxMsgIn = 1'b0, rxOverrun = 1'b0;
  logic [7:0] rdata;
  logic irq, txValid;
  logic [TXB*8-1:0] txData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canHostRegs u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .rxMsgIn(rxMsgIn), .rxOverrun(rxOverrun), .irq(irq),
    .txValid(txValid), .txData(txData)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, e);
  endtask

  task automatic pulseRx();
    @(negedge clk); rxMsgIn = 1'b1;
    @(negedge clk); rxMsgIn = 1'b0;
  endtask

  task automatic pulseOvr();
    @(negedge clk); rxOverrun = 1'b1;
    @(negedge clk); rxOverrun = 1'b0;
  endtask

  task automatic testReset();
    check("R1 irq", irq, 1'b0);
    rdChk("R1 mode", 5'd0, 8'h01);
    rdChk("R1 status", 5'd2, 8'h3C);
    rdChk("R1 flags", 5'd3, 8'h00);
    rdChk("R1 ie", 5'd4, 8'h00);
    rdChk("R1 clock", 5'd31, 8'h00);
  endtask

  task automatic testResetWindow();
    for (int i = 0; i < 8; i++) wr(5'(16 + i), 8'(8'hA0 + i));
    for (int i = 0; i < 8; i++) rdChk("R7 acc readback", 5'(16 + i), 8'(8'hA0 + i));
    rdChk("R7 addr24", 5'd24, 8'h00);
    rdChk("R7 addr28", 5'd28, 8'h00);
    check("R7 txbuf untouched", txData, '0);
    wr(5'd1, 8'h01);
    check("R5 tx ignored in reset", txValid, 1'b0);
    rdChk("R5 status in reset", 5'd2, 8'h3C);
    pulseRx();
    rdChk("R10 rx ignored status", 5'd2, 8'h3C);
    rdChk("R10 rx ignored flags", 5'd3, 8'h00);
  endtask

  task automatic testModeWrite();
    wr(5'd0, 8'hE0);
    rdChk("R2 mode low bits", 5'd0, 8'h00);
  endtask

  task automatic testTransmit();
    logic [TXB*8-1:0] expBuf;
    wr(5'd1, 8'h01);
    check("R5 txValid", txValid, 1'b1);
    @(negedge clk);
    check("R5 txValid one cycle", txValid, 1'b0);
    rdChk("R5 status after tx", 5'd2, 8'h1C);
    wr(5'd4, 8'h02);
    check("R3 irq on tx flag", irq, 1'b1);
    for (int i = 1; i < TXB; i++) wr(5'(16 + i), 8'(8'h10 + i));
    rdChk("R6 status no bit5", 5'd2, 8'h1C);
    wr(5'd16, 8'h10);
    rdChk("R6 status bit5", 5'd2, 8'h3C);
    rdChk("R6 window read", 5'd20, 8'h00);
    for (int i = 0; i < TXB; i++) expBuf[i*8 +: 8] = 8'(8'h10 + i);
    check("R6 txData", txData, expBuf);
    wr(5'd1, 8'h01);
    check("R5 txValid again", txValid, 1'b1);
    check("R5 txData", txData, expBuf);
    rdChk("R4 flag read", 5'd3, 8'h02);
    check("R3 irq after clear", irq, 1'b0);
    rdChk("R4 flag cleared", 5'd3, 8'h00);
    wr(5'd4, 8'h00);
  endtask

  task automatic testReceive();
    pulseRx();
    pulseRx();
    rdChk("R10 status rx", 5'd2, 8'h1D);
    rdChk("R4 read rx flag", 5'd3, 8'h01);
    rdChk("R4 rx flag reasserted", 5'd3, 8'h01);
    wr(5'd1, 8'h04);
    rdChk("R10 one left", 5'd2, 8'h1D);
    wr(5'd1, 8'h04);
    rdChk("R10 empty status", 5'd2, 8'h1C);
    rdChk("R10 empty flags", 5'd3, 8'h00);
    wr(5'd1, 8'h04);
    rdChk("R10 release when empty", 5'd2, 8'h1C);
  endtask

  task automatic testOverrun();
    wr(5'd4, 8'h08);
    pulseOvr();
    check("R11 irq", irq, 1'b1);
    rdChk("R11 status", 5'd2, 8'h1E);
    wr(5'd1, 8'h08);
    rdChk("R11 cleared", 5'd2, 8'h1C);
    check("R11 irq cleared", irq, 1'b0);
    wr(5'd4, 8'h00);
  endtask

  task automatic testIgnoredWrites();
    wr(5'd2, 8'hFF);
    rdChk("R9 status write", 5'd2, 8'h1C);
    wr(5'd3, 8'hFF);
    rdChk("R9 flag write", 5'd3, 8'h00);
  endtask

  task automatic testReadMap();
    rdChk("R8 cmd", 5'd1, 8'h00);
    rdChk("R8 addr9", 5'd9, 8'h00);
    rdChk("R8 addr15", 5'd15, 8'h00);
    rdChk("R8 addr29", 5'd29, 8'hFF);
    rdChk("R8 addr30", 5'd30, 8'hFF);
    wr(5'd31, 8'h5A);
    rdChk("R8 clock", 5'd31, 8'h5A);
  endtask

  task automatic testSameCycle();
    logic [7:0] d;
    @(negedge clk); addr = 5'd3; re = 1'b1; rxOverrun = 1'b1;
    @(negedge clk); re = 1'b0; rxOverrun = 1'b0; d = rdata;
    check("R12 read during ovr", d, 8'h00);
    check("R13 rdata holds", rdata, 8'h00);
    rdChk("R12 ovr kept", 5'd3, 8'h08);
    @(negedge clk); addr = 5'd1; wdata = 8'h08; we = 1'b1; rxOverrun = 1'b1;
    @(negedge clk); we = 1'b0; rxOverrun = 1'b0;
    rdChk("R12 ovr beats clear status", 5'd2, 8'h1E);
    rdChk("R12 ovr beats clear flag", 5'd3, 8'h08);
    wr(5'd1, 8'h08);
    rdChk("R11 final clear", 5'd3, 8'h00);
    pulseRx();
    @(negedge clk); addr = 5'd1; wdata = 8'h04; we = 1'b1; rxMsgIn = 1'b1;
    @(negedge clk); we = 1'b0; rxMsgIn = 1'b0;
    rdChk("R12 rx with release", 5'd2, 8'h1D);
    wr(5'd1, 8'h04);
    rdChk("R12 count was one", 5'd2, 8'h1C);
    rdChk("R12 flags empty", 5'd3, 8'h00);
  endtask

  task automatic testLeaveReset();
    pulseRx();
    wr(5'd0, 8'h01);
    rdChk("R2 enter reset", 5'd0, 8'h01);
    wr(5'd0, 8'h00);
    rdChk("R2 stale flag", 5'd3, 8'h01);
    rdChk("R2 count zeroed", 5'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testResetWindow();
    testModeWrite();
    testTransmit();
    testReceive();
    testOverrun();
    testIgnoredWrites();
    testReadMap();
    testSameCycle();
    testLeaveReset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule